// File: doc/BRIEF.md
# Compressed-Code Line Address Lookaside Buffer

This block sits beside an instruction cache whose lines are held compressed in instruction memory. For each instruction line the fetch unit presents, it finds the byte address where that line's compressed image begins. Lines are grouped eight to a table record. Each 64-bit record holds a 24-bit pointer to the first compressed line of its group, followed by eight 5-bit length fields. The block keeps a few recently used records in a fully associative store, tagged by the group number.

On a hit the start address comes back in the same cycle. It is the pointer plus the masked and summed lengths of the lines that come before the requested one in its group. On a miss the block reads the 8-byte record as two 32-bit words from memory at a table base plus eight times the group number. It installs the record over the least recently used entry and then answers.

The controller is a four-state machine. `IDLE` accepts lookups and answers hits. `IDLE -> FETCH_HI` on a miss. `FETCH_HI -> FETCH_LO` when the first word returns. `FETCH_LO -> RESPOND` when the second word returns and the record is installed. `RESPOND -> IDLE` unconditionally. Any fetch state goes back to `IDLE` when a flush arrives.

Top module: `line_addr_lookaside`

## Requirements
- R1: After reset every entry is invalid, `req_ready` is 1, and `resp_valid` and `mem_req` are 0.
- R2: A lookup in IDLE whose group number `req_line[18:3]` matches a valid entry gives `resp_valid=1` and `resp_hit=1` in the same cycle, and it makes no memory request.
- R3: `resp_start` equals the record pointer plus the sum of the effective lengths of fields 0 to k-1, where k is `req_line[2:0]`. A length field of 0 counts as 32. The addition wraps modulo 2^24.
- R4: `resp_len` is the effective length of field k, between 1 and 32. `resp_raw` is 1 exactly when field k is 0, and `resp_len` is then 32.
- R5: The record is {first word, second word}. The pointer is in record bits [63:40], and field i is in bits [39-5i : 35-5i]. The first word is read at the lower address.
- R6: On a miss, `mem_req` is held with `mem_addr` = `tbl_base` + 8*group (mod 2^24) until `mem_rvalid`, and then the same for address +4. In the cycle after the second word, `resp_valid=1` with `resp_hit=0` and the result of R3 and R4 from the new record.
- R7: While a fill is in progress, `req_ready` is 0 and `req_valid` is ignored. No response or state change comes from it.
- R8: `flush` invalidates every entry and aborts any fill without installing it or responding. In that cycle `req_ready` and `resp_valid` are 0.
- R9: A miss installs into the lowest-numbered invalid entry. If every entry is valid, it installs over the least recently used entry. Hits and installs both count as use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Invalidate all entries, abort a fill |
| tbl_base | input | 24 | Byte address of the table in memory |
| req_valid | input | 1 | Lookup request |
| req_line | input | 19 | Instruction line address (instruction address bits 23:5) |
| req_ready | output | 1 | Lookup accepted this cycle |
| resp_valid | output | 1 | Result valid |
| resp_hit | output | 1 | Result came from a stored entry |
| resp_start | output | 24 | Start byte address of the compressed line |
| resp_raw | output | 1 | Line is stored uncompressed |
| resp_len | output | 6 | Stored byte length of the line |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 24 | Memory read byte address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
The bench sweeps every position within a group for several groups. The groups include records with zero lengths mixed in, a record of all zero lengths whose pointer wraps past 2^24, and a record of all maximum lengths. This separates errors in the masking boundary, the zero-means-32 substitution and the field positions. A pseudo-random mix of six groups over four entries exercises hit/miss order against an LRU model, which exposes a wrong victim choice. Flushes in IDLE and in the middle of a fill, a request held during a fill, and a table base near the top of memory test abort, ignore and address wrap.

// File: rtl/lal_pkg.sv
package lal_pkg;
    localparam int ADDR_W    = 24;
    localparam int BLK_SHIFT = 5;
    localparam int LINE_W    = ADDR_W - BLK_SHIFT;
    localparam int SEL_W     = 3;
    localparam int TAG_W     = LINE_W - SEL_W;
    localparam int N_LEN     = 1 << SEL_W;
    localparam int LEN_W     = 5;
    localparam int BASE_W    = 24;
    localparam int ENTRY_W   = BASE_W + N_LEN * LEN_W;
    localparam int BASE_LSB  = ENTRY_W - BASE_W;
    localparam int WORD_W    = 32;
    localparam int OLEN_W    = LEN_W + 1;

    typedef logic [ENTRY_W-1:0] lat_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FETCH_HI = 2'd1,
        ST_FETCH_LO = 2'd2,
        ST_RESPOND  = 2'd3
    } fill_state_e;
endpackage

// File: rtl/lal_tag_store.sv
module lal_tag_store
    import lal_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  lat_entry_t         wr_data,
    input  logic [TAG_W-1:0]   lk_tag,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output lat_entry_t         hit_data,
    output logic [ENTRIES-1:0] valid_vec
);
    logic [TAG_W-1:0] tag_q  [ENTRIES];
    lat_entry_t       data_q [ENTRIES];
    logic [ENTRIES-1:0] match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_vec <= '0;
        end else if (flush) begin
            valid_vec <= '0;
        end else if (wr_en) begin
            valid_vec[wr_idx] <= 1'b1;
        end
    end

    genvar g;
    for (g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q[g]  <= '0;
                data_q[g] <= '0;
            end else if (wr_en && !flush && wr_idx == IDX_W'(g)) begin
                tag_q[g]  <= wr_tag;
                data_q[g] <= wr_data;
            end
        end
        assign match[g] = valid_vec[g] && (tag_q[g] == lk_tag);
    end

    always_comb begin
        hit      = |match;
        hit_idx  = '0;
        hit_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                hit_idx  = IDX_W'(i);
                hit_data = data_q[i];
            end
        end
    end
endmodule

// File: rtl/lal_lru.sv
module lal_lru #(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch,
    input  logic [IDX_W-1:0]   touch_idx,
    input  logic [ENTRIES-1:0] valid_vec,
    output logic [IDX_W-1:0]   victim
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] age_q [ENTRIES];
    logic [IDX_W-1:0] touched_age;

    assign touched_age = age_q[touch_idx];

    genvar g;
    for (g = 0; g < ENTRIES; g++) begin : g_age
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                age_q[g] <= IDX_W'(g);
            end else if (touch) begin
                if (touch_idx == IDX_W'(g)) begin
                    age_q[g] <= '0;
                end else if (age_q[g] < touched_age) begin
                    age_q[g] <= age_q[g] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        logic any_free;
        any_free = ~&valid_vec;
        victim   = '0;
        if (any_free) begin
            for (int i = ENTRIES - 1; i >= 0; i--) begin
                if (!valid_vec[i]) victim = IDX_W'(i);
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (age_q[i] == OLDEST) victim = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/lal_sum_unit.sv
module lal_sum_unit
    import lal_pkg::*;
(
    input  lat_entry_t         entry,
    input  logic [SEL_W-1:0]   sel,
    output logic [ADDR_W-1:0]  start,
    output logic               raw,
    output logic [OLEN_W-1:0]  len
);
    localparam int L1_W = OLEN_W + 1;
    localparam int L2_W = OLEN_W + 2;
    localparam int L3_W = OLEN_W + 3;
    localparam logic [OLEN_W-1:0] FULL_LEN = OLEN_W'(1 << LEN_W);

    logic [LEN_W-1:0]  fld  [N_LEN];
    logic [OLEN_W-1:0] eff  [N_LEN];
    logic [OLEN_W-1:0] msk  [N_LEN];
    logic [L1_W-1:0]   lvl1 [N_LEN/2];
    logic [L2_W-1:0]   lvl2 [N_LEN/4];
    logic [L3_W-1:0]   total;

    genvar g;
    for (g = 0; g < N_LEN; g++) begin : g_fld
        assign fld[g] = entry[BASE_LSB-1-LEN_W*g -: LEN_W];
        assign eff[g] = (fld[g] == '0) ? FULL_LEN : {1'b0, fld[g]};
        assign msk[g] = (SEL_W'(g) < sel) ? eff[g] : '0;
    end
    for (g = 0; g < N_LEN/2; g++) begin : g_l1
        assign lvl1[g] = {1'b0, msk[2*g]} + {1'b0, msk[2*g+1]};
    end
    for (g = 0; g < N_LEN/4; g++) begin : g_l2
        assign lvl2[g] = {1'b0, lvl1[2*g]} + {1'b0, lvl1[2*g+1]};
    end
    assign total = {1'b0, lvl2[0]} + {1'b0, lvl2[1]};

    assign start = entry[ENTRY_W-1 -: BASE_W] + ADDR_W'(total);
    assign raw   = (fld[sel] == '0);
    assign len   = eff[sel];
endmodule

// File: rtl/line_addr_lookaside.sv
module line_addr_lookaside
    import lal_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [ADDR_W-1:0]  tbl_base,
    input  logic               req_valid,
    input  logic [LINE_W-1:0]  req_line,
    output logic               req_ready,
    output logic               resp_valid,
    output logic               resp_hit,
    output logic [ADDR_W-1:0]  resp_start,
    output logic               resp_raw,
    output logic [OLEN_W-1:0]  resp_len,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rvalid,
    input  logic [WORD_W-1:0]  mem_rdata
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(WORD_W / 8);

    fill_state_e state_q, state_nx;
    logic [LINE_W-1:0] hold_line;
    logic [WORD_W-1:0] hi_word;
    logic [LINE_W-1:0] active_line;
    logic [TAG_W-1:0]  active_tag;

    logic              tag_hit;
    logic [IDX_W-1:0]  hit_idx;
    lat_entry_t        hit_data;
    logic [ENTRIES-1:0] valid_vec;
    logic [IDX_W-1:0]  victim;
    logic              wr_en;
    logic              touch;
    logic [IDX_W-1:0]  touch_idx;
    logic [ADDR_W-1:0] rec_addr;

    assign active_line = (state_q == ST_IDLE) ? req_line : hold_line;
    assign active_tag  = active_line[LINE_W-1 -: TAG_W];
    assign rec_addr    = tbl_base + ADDR_W'({hold_line[LINE_W-1 -: TAG_W], 3'b000});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:     if (!flush && req_valid && !tag_hit) state_nx = ST_FETCH_HI;
            ST_FETCH_HI: if (flush) state_nx = ST_IDLE;
                         else if (mem_rvalid) state_nx = ST_FETCH_LO;
            ST_FETCH_LO: if (flush) state_nx = ST_IDLE;
                         else if (mem_rvalid) state_nx = ST_RESPOND;
            ST_RESPOND:  state_nx = ST_IDLE;
        endcase
    end

    // outputs and control
    always_comb begin
        req_ready  = (state_q == ST_IDLE) && !flush;
        resp_valid = !flush && (((state_q == ST_IDLE) && req_valid && tag_hit)
                                || (state_q == ST_RESPOND));
        resp_hit   = (state_q == ST_IDLE);
        mem_req    = (state_q == ST_FETCH_HI) || (state_q == ST_FETCH_LO);
        mem_addr   = (state_q == ST_FETCH_LO) ? rec_addr + WORD_STEP : rec_addr;
        wr_en      = (state_q == ST_FETCH_LO) && mem_rvalid && !flush;
        touch      = wr_en || (resp_valid && (state_q == ST_IDLE));
        touch_idx  = wr_en ? victim : hit_idx;
    end

    // datapath holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_line <= '0;
            hi_word   <= '0;
        end else begin
            if (req_ready && req_valid) hold_line <= req_line;
            if ((state_q == ST_FETCH_HI) && mem_rvalid) hi_word <= mem_rdata;
        end
    end

    lal_tag_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .wr_en     (wr_en),
        .wr_idx    (victim),
        .wr_tag    (hold_line[LINE_W-1 -: TAG_W]),
        .wr_data   ({hi_word, mem_rdata}),
        .lk_tag    (active_tag),
        .hit       (tag_hit),
        .hit_idx   (hit_idx),
        .hit_data  (hit_data),
        .valid_vec (valid_vec)
    );

    lal_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (touch),
        .touch_idx (touch_idx),
        .valid_vec (valid_vec),
        .victim    (victim)
    );

    lal_sum_unit u_sum (
        .entry (hit_data),
        .sel   (active_line[SEL_W-1:0]),
        .start (resp_start),
        .raw   (resp_raw),
        .len   (resp_len)
    );
endmodule

// File: rtl/line_addr_lookaside_chk.sv
module line_addr_lookaside_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       flush,
    input logic       req_ready,
    input logic       resp_valid,
    input logic       resp_hit,
    input logic       resp_raw,
    input logic [5:0] resp_len,
    input logic       mem_req,
    input logic       mem_rvalid,
    input logic       tag_hit
);
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_len >= 6'd1 && resp_len <= 6'd32)); // R4
    AST_RAW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_raw |-> resp_len == 6'd32); // R4
    AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_hit |-> !mem_req); // R2
    AST_MEMREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rvalid && !flush |=> mem_req); // R6
    AST_FILL_INSTALLED: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_hit |-> tag_hit); // R6
    AST_MISS_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_hit |-> $past(mem_rvalid)); // R6
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready); // R7
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !resp_valid); // R8
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !req_ready && !resp_valid); // R8
endmodule

bind line_addr_lookaside line_addr_lookaside_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .resp_raw   (resp_raw),
    .resp_len   (resp_len),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid),
    .tag_hit    (tag_hit)
);

// File: tb/tb_line_addr_lookaside.sv
module tb_line_addr_lookaside;
    localparam int N       = 4;
    localparam int MEM_LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [23:0] tbl_base = 24'h40_0000;
    logic        req_valid = 1'b0;
    logic [18:0] req_line = '0;
    logic        req_ready, resp_valid, resp_hit, resp_raw, mem_req;
    logic [23:0] resp_start, mem_addr;
    logic [5:0]  resp_len;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rd_cnt = 0;
    int lat_cnt = 0;
    logic [23:0] addr_prev = '0, addr_last = '0;

    bit mval [N];
    logic [15:0] mtag [N];
    int mage [N];

    bit got;
    bit c_hit, c_raw;
    logic [23:0] c_start;
    logic [5:0] c_len;

    always #10 clk = ~clk;

    line_addr_lookaside #(.ENTRIES(N)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .tbl_base(tbl_base),
        .req_valid(req_valid), .req_line(req_line), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_start(resp_start),
        .resp_raw(resp_raw), .resp_len(resp_len), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [63:0] tbl_entry(input logic [15:0] idx);
        logic [63:0] e;
        if (idx == 16'hFFFF) return {24'hFF_FFF0, 40'h0};
        if (idx == 16'hFFFE) return {24'h00_0100, {8{5'd31}}};
        e[63:40] = {idx[7:0], 16'h0} + 24'h00_1000 + 24'(idx) * 24'd3;
        for (int i = 0; i < 8; i++) e[39-5*i -: 5] = 5'((int'(idx) * 13 + i * 9) % 32);
        return e;
    endfunction

    function automatic logic [31:0] word_at(input logic [23:0] a);
        logic [23:0] off;
        logic [63:0] e;
        off = a - tbl_base;
        e = tbl_entry(off[18:3]);
        return a[2] ? e[31:0] : e[63:32];
    endfunction

    always @(negedge clk) begin
        if (mem_req && !mem_rvalid) begin
            if (lat_cnt == MEM_LAT) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= word_at(mem_addr);
                addr_prev  <= addr_last;
                addr_last  <= mem_addr;
                rd_cnt     <= rd_cnt + 1;
                lat_cnt    <= 0;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            mem_rvalid <= 1'b0;
            lat_cnt    <= 0;
        end
    end

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            report();
            $finish;
        end
    end

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic bit model_access(input logic [15:0] t);
        int k = -1;
        int old;
        bit h = 1'b0;
        for (int i = 0; i < N; i++) if (mval[i] && mtag[i] == t) begin k = i; h = 1'b1; end
        if (!h) begin
            for (int i = N - 1; i >= 0; i--) if (!mval[i]) k = i;
            if (k < 0) for (int i = 0; i < N; i++) if (mage[i] == N - 1) k = i;
            mval[k] = 1'b1;
            mtag[k] = t;
        end
        old = mage[k];
        for (int i = 0; i < N; i++) begin
            if (i == k) mage[i] = 0;
            else if (mage[i] < old) mage[i]++;
        end
        return h;
    endfunction

    task automatic model_flush;
        for (int i = 0; i < N; i++) mval[i] = 1'b0;
    endtask

    task automatic sample_resp;
        if (resp_valid && !got) begin
            got = 1'b1; c_hit = resp_hit; c_start = resp_start; c_raw = resp_raw; c_len = resp_len;
        end
    endtask

    task automatic finish_check(input logic [18:0] ln, input bit eh, input int rb);
        logic [63:0] e;
        logic [23:0] es, ea;
        logic [4:0] f;
        int n = 0;
        while (!got && n < 60) begin
            #2 sample_resp();
            if (!got) @(negedge clk);
            n++;
        end
        e = tbl_entry(ln[18:3]);
        es = e[63:40];
        for (int i = 0; i < int'(ln[2:0]); i++) begin
            f = e[39-5*i -: 5];
            es = es + ((f == 0) ? 24'd32 : 24'(f));
        end
        f = e[39-5*int'(ln[2:0]) -: 5];
        chk("R6", "response arrived", 32'(got), 32'd1);
        chk(eh ? "R2" : "R9", "hit flag vs LRU model", 32'(c_hit), 32'(eh));
        chk("R3", "start address", 32'(c_start), 32'(es));
        chk("R4", "raw flag", 32'(c_raw), 32'(f == 0));
        chk("R4", "length", 32'(c_len), (f == 0) ? 32'd32 : 32'(f));
        chk(eh ? "R2" : "R6", "memory reads", 32'(rd_cnt - rb), eh ? 32'd0 : 32'd2);
        if (!eh) begin
            ea = tbl_base + 24'({ln[18:3], 3'b000});
            chk("R6", "first word address", 32'(addr_prev), 32'(ea));
            chk("R5", "second word address", 32'(addr_last), 32'(ea + 24'd4));
        end
    endtask

    task automatic lookup(input logic [18:0] ln);
        bit eh;
        int rb;
        eh = model_access(ln[18:3]);
        rb = rd_cnt;
        got = 1'b0;
        @(negedge clk);
        req_valid = 1'b1;
        req_line  = ln;
        #2 sample_resp();
        @(negedge clk);
        req_valid = 1'b0;
        finish_check(ln, eh, rb);
    endtask

    task automatic do_flush;
        @(negedge clk);
        flush = 1'b1;
        #2;
        chk("R8", "ready during flush", 32'(req_ready), 32'd0);
        @(negedge clk);
        flush = 1'b0;
        model_flush();
    endtask

    initial begin
        logic [15:0] groups [8];
        int seed = 7;
        bit eh;
        int rb, seen;
        for (int i = 0; i < N; i++) begin mval[i] = 0; mage[i] = i; mtag[i] = 0; end
        groups = '{16'd0, 16'd1, 16'd2, 16'd3, 16'd4, 16'd5, 16'hFFFE, 16'hFFFF};

        repeat (3) @(negedge clk);
        #2;
        chk("R1", "req_ready after reset", 32'(req_ready), 32'd1);
        chk("R1", "resp_valid in reset", 32'(resp_valid), 32'd0);
        chk("R1", "mem_req in reset", 32'(mem_req), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R1", "req_ready after reset", 32'(req_ready), 32'd1);
        chk("R1", "mem_req after reset", 32'(mem_req), 32'd0);

        // sweep every line position of each group
        for (int g = 0; g < 8; g++)
            for (int s = 0; s < 8; s++) lookup({groups[g], 3'(s)});

        // pseudo-random mix of six groups to exercise replacement order (R9)
        for (int k = 0; k < 150; k++) begin
            seed = seed * 1103515245 + 12345;
            lookup({16'((seed >>> 16) & 32'h7FFF) % 16'd6, 3'(seed >>> 8)});
        end

        // flush in IDLE: former entries must miss (R8)
        do_flush();
        lookup({16'd2, 3'd5});
        lookup({16'd2, 3'd1});

        // request during a fill is ignored (R7)
        got = 1'b0;
        eh = model_access(16'd9);
        rb = rd_cnt;
        @(negedge clk);
        req_valid = 1'b1;
        req_line = {16'd9, 3'd6};
        #2 sample_resp();
        @(negedge clk);
        req_line = {16'd2, 3'd5};
        #2;
        chk("R7", "ready during fill", 32'(req_ready), 32'd0);
        chk("R7", "no response to held request", 32'(resp_valid), 32'd0);
        sample_resp();
        @(negedge clk);
        req_valid = 1'b0;
        finish_check({16'd9, 3'd6}, eh, rb);
        lookup({16'd2, 3'd1});

        // flush in the middle of a fill (R8)
        @(negedge clk);
        req_valid = 1'b1;
        req_line = {16'd30, 3'd2};
        @(negedge clk);
        req_valid = 1'b0;
        flush = 1'b1;
        #2;
        chk("R8", "ready during flush", 32'(req_ready), 32'd0);
        chk("R8", "response during flush", 32'(resp_valid), 32'd0);
        @(negedge clk);
        flush = 1'b0;
        model_flush();
        seen = 0;
        for (int k = 0; k < 10; k++) begin
            #2 if (resp_valid) seen++;
            @(negedge clk);
        end
        chk("R8", "responses after aborted fill", 32'(seen), 32'd0);
        lookup({16'd30, 3'd2});

        // table base near top of memory: record address wraps (R6)
        do_flush();
        tbl_base = 24'hFF_FFF8;
        lookup({16'd1, 3'd3});
        lookup({16'd0, 3'd7});
        lookup({16'hFFFF, 3'd7});

        report();
        $finish;
    end
endmodule